// File: doc/BRIEF.md
# Prioritized Two-Level Interrupt Controller

This block collects interrupt requests from up to 32 peripheral lines and presents them to a processor that has two interrupt inputs: a normal one and a fast one. Every rising edge on a request line is captured in a latched-request register. A per-source routing register sends each source to either the normal or the fast processor line. A per-source block register keeps a source off both lines, but its captured request is still kept.

Normal-routed sources compete by fixed priority, with the lowest source index winning. The winner is recorded in a one-hot in-service register. That register is reloaded only when it is empty, so a bit that is being serviced is never replaced by a later, more urgent request. The fast line is driven directly from any unblocked fast-routed request, so it does not wait on the in-service choice and takes precedence over the normal line. When a handler finishes, software clears the source's bit in both the latched-request register and the in-service register, using write-one-to-clear writes.

Access is through a simple register port with write and read strobes, a 2-bit register offset and a 32-bit data word. Read data is registered.

Top module: `prio_intc`

## Requirements
- R1: After reset, all four registers read 0, rdata is 0, and both `norm_req_n` and `fast_req_n` are 1 (inactive).
- R2: A 0-to-1 change on `src_req[i]` sets bit i of the latched-request register (offset 0) at that clock edge. The bit is set even when source i is blocked. A line held high sets it only once. A line that is already high while reset is asserted does not set it. When a new edge and a clear of the same bit arrive in the same cycle, the new edge wins.
- R3: Writing offset 0 clears each latched-request bit whose `wdata` bit is 1. Bits written as 0 keep their value.
- R4: Offset 1 (routing: bit=1 fast, bit=0 normal) and offset 2 (block: bit=1 blocked) are plain read/write registers.
- R5: The in-service register (offset 3) never has more than one bit set. When it is 0, the next edge loads the lowest-index bit that is latched, unblocked and normal-routed.
- R6: While the in-service register is non-zero, it changes only through a write to offset 3, which clears each bit whose `wdata` bit is 1. A newly latched request of higher priority does not replace the held bit.
- R7: `norm_req_n` is 0 in the cycle after the in-service register is non-zero, and 1 in the cycle after it is 0.
- R8: `fast_req_n` is 0 in the cycle after any source is latched, unblocked and fast-routed, and 1 otherwise. A fast-routed source never enters the in-service register.
- R9: With `rd_en` high at an edge, `rdata` takes the value the register at `addr` held before that edge. With `rd_en` low, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Level request lines from peripherals |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register offset: 0 latched, 1 routing, 2 block, 3 in-service |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| norm_req_n | output | 1 | Normal interrupt to processor, active low |
| fast_req_n | output | 1 | Fast interrupt to processor, active low |

## Verification
A latched bit that is wrong shows up on `fast_req_n` one cycle later for a fast-routed source. For a normal source it shows up when the in-service register next empties, because the wrong source is then picked. A wrong in-service bit shows on `norm_req_n` one edge later and on any read of offset 3. A fault in the hold-until-cleared rule is exposed only when a higher-priority request arrives during service, so the bench stages exactly that. The bench's behavioural model compares all three outputs on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    OFS_LATCH  = 2'd0,
    OFS_ROUTE  = 2'd1,
    OFS_BLOCK  = 2'd2,
    OFS_ACTIVE = 2'd3
  } ofs_e;

  localparam int ADDR_W = 2;
endpackage

// File: rtl/intc_latch.sv
module intc_latch #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend,
  output logic [N-1:0] req_prev
);
  logic [N-1:0] edge_hit;
  logic [N-1:0] pend_d;

  assign edge_hit = req & ~req_prev;

  always_comb begin
    pend_d = pend;
    if (clr_en) pend_d = pend_d & ~clr_bits;
    pend_d = pend_d | edge_hit;
  end

  // Previous level tracks the line through reset so a line held high
  // across reset is not taken as an edge.
  always_ff @(posedge clk) begin
    req_prev <= req;
    if (rst) pend <= '0;
    else     pend <= pend_d;
  end
endmodule

// File: rtl/intc_cfg.sv
module intc_cfg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         route_we,
  input  logic         block_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] route,
  output logic [N-1:0] block
);
  always_ff @(posedge clk) begin
    if (rst) begin
      route <= '0;
      block <= '0;
    end else begin
      if (route_we) route <= wdata;
      if (block_we) block <= wdata;
    end
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] onehot
);
  always_comb begin
    logic found;
    found  = 1'b0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i] && !found) begin
        onehot[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_serve.sv
module intc_serve #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] route,
  input  logic [N-1:0] block,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] active
);
  logic [N-1:0] eligible;
  logic [N-1:0] winner;
  logic         empty;

  assign eligible = pend & ~block & ~route;
  assign empty    = (active == '0);

  intc_pick #(.N(N)) u_pick (
    .vec    (eligible),
    .onehot (winner)
  );

  always_ff @(posedge clk) begin
    if (rst)          active <= '0;
    else if (empty)   active <= winner;
    else if (clr_en)  active <= active & ~clr_bits;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  output logic              norm_req_n,
  output logic              fast_req_n
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] req_prev;
  logic [N_SRC-1:0] route_q;
  logic [N_SRC-1:0] block_q;
  logic [N_SRC-1:0] active_q;
  logic             we_latch, we_route, we_block, we_active;

  assign we_latch  = wr_en && (ofs_e'(addr) == OFS_LATCH);
  assign we_route  = wr_en && (ofs_e'(addr) == OFS_ROUTE);
  assign we_block  = wr_en && (ofs_e'(addr) == OFS_BLOCK);
  assign we_active = wr_en && (ofs_e'(addr) == OFS_ACTIVE);

  intc_latch #(.N(N_SRC)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .req      (src_req),
    .clr_en   (we_latch),
    .clr_bits (wdata),
    .pend     (pend_q),
    .req_prev (req_prev)
  );

  intc_cfg #(.N(N_SRC)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .route_we (we_route),
    .block_we (we_block),
    .wdata    (wdata),
    .route    (route_q),
    .block    (block_q)
  );

  intc_serve #(.N(N_SRC)) u_serve (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_q),
    .route    (route_q),
    .block    (block_q),
    .clr_en   (we_active),
    .clr_bits (wdata),
    .active   (active_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      norm_req_n <= 1'b1;
      fast_req_n <= 1'b1;
    end else begin
      norm_req_n <= (active_q == '0);
      fast_req_n <= ((pend_q & route_q & ~block_q) == '0);
      if (rd_en) begin
        case (ofs_e'(addr))
          OFS_LATCH:  rdata <= pend_q;
          OFS_ROUTE:  rdata <= route_q;
          OFS_BLOCK:  rdata <= block_q;
          default:    rdata <= active_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] src_req,
  input logic [N-1:0] req_prev,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] route_q,
  input logic [N-1:0] block_q,
  input logic [N-1:0] active_q,
  input logic         norm_req_n,
  input logic         fast_req_n
);
  // R5: at most one bit in service
  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_q));

  // R6: held bit survives unless offset 3 is written
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    ((active_q != '0) && !(wr_en && addr == 2'd3)) |=> $stable(active_q));

  // R2: a detected edge always leaves its latched bit set
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(src_req) & ~$past(req_prev)) & ~pend_q) == '0));

  // R7: normal line follows in-service register one cycle later
  a_r7_norm_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (norm_req_n == ($past(active_q) == '0)));

  // R8: fast line follows unblocked fast-routed latched requests
  a_r8_fast_line: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fast_req_n == (($past(pend_q) & $past(route_q) & ~$past(block_q)) == '0)));
endmodule

bind prio_intc prio_intc_chk #(.N(N_SRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_req    (src_req),
  .req_prev   (req_prev),
  .wr_en      (wr_en),
  .addr       (addr),
  .pend_q     (pend_q),
  .route_q    (route_q),
  .block_q    (block_q),
  .active_q   (active_q),
  .norm_req_n (norm_req_n),
  .fast_req_n (fast_req_n)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         norm_req_n, fast_req_n;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  prio_intc #(.N_SRC(N)) uut (
    .clk(clk), .rst(rst), .src_req(src_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .norm_req_n(norm_req_n), .fast_req_n(fast_req_n)
  );

  // Behavioural reference model
  logic [N-1:0] m_pend, m_route, m_block, m_act, m_prev, m_rdata;
  logic         m_norm_n, m_fast_n;
  logic [N-1:0] t_pend, t_act, t_cand;

  always @(posedge clk) begin
    m_prev <= src_req;
    if (rst) begin
      m_pend <= '0; m_route <= '0; m_block <= '0; m_act <= '0;
      m_rdata <= '0; m_norm_n <= 1'b1; m_fast_n <= 1'b1;
    end else begin
      m_norm_n <= (m_act == 0);
      m_fast_n <= ((m_pend & m_route & ~m_block) == 0);
      if (rd_en)
        m_rdata <= (addr == 0) ? m_pend : (addr == 1) ? m_route :
                   (addr == 2) ? m_block : m_act;
      t_pend = m_pend;
      if (wr_en && addr == 0) t_pend = t_pend & ~wdata;
      t_pend = t_pend | (src_req & ~m_prev);
      m_pend <= t_pend;
      if (wr_en && addr == 1) m_route <= wdata;
      if (wr_en && addr == 2) m_block <= wdata;
      t_act = m_act;
      if (m_act == 0) begin
        t_cand = m_pend & ~m_block & ~m_route;
        for (int i = N - 1; i >= 0; i--)
          if (t_cand[i]) t_act = N'(1) << i;
      end else if (wr_en && addr == 3) begin
        t_act = m_act & ~wdata;
      end
      m_act <= t_act;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      if (rdata !== m_rdata || norm_req_n !== m_norm_n || fast_req_n !== m_fast_n) begin
        fails++;
        $display("FAIL %s per-cycle: rdata=%h/%h norm_n=%b/%b fast_n=%b/%b (actual/expected)",
                 cur_req, rdata, m_rdata, norm_req_n, m_norm_n, fast_req_n, m_fast_n);
      end
    end
  end

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    src_req = 32'h0000_8000;      // R2: held high through reset, must not latch
    idle(4);
    rst = 1'b0;
    idle(2);
    cur_req = "R1";
    check("R1 rdata", rdata, '0);
    check("R1 norm_n", N'(norm_req_n), N'(1));
    check("R1 fast_n", N'(fast_req_n), N'(1));
    for (int k = 0; k < 4; k++) begin
      rd(2'(k), v);
      check((k == 0) ? "R1/R2 latched after reset" : "R1 reg after reset", v, '0);
    end

    cur_req = "R4";
    wr(1, 32'h0000_0080);          // source 7 fast
    wr(2, 32'h0000_0400);          // source 10 blocked
    rd(1, v); check("R4 route readback", v, 32'h0000_0080);
    rd(2, v); check("R4 block readback", v, 32'h0000_0400);

    cur_req = "R2";
    @(negedge clk); src_req = 32'h0000_8628;   // sources 3,5,9,10 rise
    idle(3);
    rd(0, v); check("R2 latched incl blocked", v, 32'h0000_0628);

    cur_req = "R5";
    rd(3, v); check("R5 lowest index in service", v, 32'h0000_0008);
    cur_req = "R7";
    check("R7 norm line low", N'(norm_req_n), N'(0));
    check("R8 fast line idle", N'(fast_req_n), N'(1));

    cur_req = "R6";
    @(negedge clk); src_req = src_req | 32'h2;   // source 1 rises during service
    idle(3);
    rd(3, v); check("R6 held bit not replaced", v, 32'h0000_0008);
    rd(0, v); check("R6 source 1 latched", v, 32'h0000_062A);

    cur_req = "R3";
    wr(0, 32'h0);
    wr(3, 32'h0);
    rd(0, v); check("R3 zero write keeps latched", v, 32'h0000_062A);
    rd(3, v); check("R6 zero write keeps service", v, 32'h0000_0008);

    wr(0, 32'h0000_0008);
    wr(3, 32'h0000_0008);
    idle(2);
    rd(3, v); check("R5 reload picks source 1", v, 32'h0000_0002);
    rd(0, v); check("R3 bit 3 cleared, held level no re-set", v, 32'h0000_0622);

    cur_req = "R8";
    @(negedge clk); src_req = src_req | 32'h80;  // fast source 7
    idle(3);
    check("R8 fast line low", N'(fast_req_n), N'(0));
    rd(3, v); check("R8 fast source not in service", v, 32'h0000_0002);
    wr(2, 32'h0000_0480);
    idle(2);
    check("R8 blocked fast source idle", N'(fast_req_n), N'(1));

    cur_req = "R2";
    @(negedge clk);                               // edge and clear same cycle
    src_req = src_req | 32'h1000; wr_en = 1'b1; addr = 2'd0; wdata = 32'h1000;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    rd(0, v); check("R2 edge beats clear", v, 32'h0000_16A2);

    cur_req = "R9";
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 32'hFFFF_0000;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
    check("R9 rdata held without read", rdata, 32'h0000_16A2);

    cur_req = "R7";
    wr(1, 32'h0);
    wr(0, 32'hFFFF_FFFF);
    wr(3, 32'h0000_0002);
    idle(3);
    check("R7 norm line released", N'(norm_req_n), N'(1));
    rd(3, v); check("R5 empty when nothing eligible", v, '0);

    cur_req = "R2";
    @(negedge clk); src_req = '0;
    @(negedge clk); src_req = 32'h0000_0020;      // source 5 rises again
    idle(3);
    rd(3, v); check("R2/R5 re-edge latched and served", v, 32'h0000_0020);

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule